// File: doc/BRIEF.md
# Trigger Menu Accept Former

Once per bunch crossing this block takes a vector of trigger-input bits and forms a smaller set of trigger items. Each item fires when every input picked by its selection mask is set. A fired item then passes through its own enable bit and its own prescaler. What survives is gated by an external busy, a short dead-time window and a longer window that only affects low-priority items. The accept is the OR of the items left after gating.

With each accept the block registers three item vectors for readout: raw firings, firings after enable and prescale, and firings after the veto. It also registers a trigger-type word that holds the index of the lowest-numbered surviving item. A single-cycle write port programs the item selections, the enables, the priorities, the prescale ratios and the two dead-time lengths while the block is running.

Top module: `trig_menu_accept`

## Requirements
- R1: After reset, accept is 0, ttype is 0 and all three readout vectors are 0. No item is enabled and all dead-time lengths are 0.
- R2: An item fires raw when every input bit set in its selection mask is 1. An item whose mask is empty never fires. rd_raw reports raw firings before the enable bit is applied.
- R3: An item whose enable bit is 0 never causes an accept, but it still appears in rd_raw.
- R4: A prescale ratio N passes the Nth, 2Nth, ... enabled firings of its item. The count advances even when the item is later vetoed. A ratio of 0 acts as 1. Writing an item's settings clears its count.
- R5: accept rises in the cycle after the sampled crossing and equals the OR of the post-veto items.
- R6: While busy is 1 at a crossing, that crossing gives no accept.
- R7: After an accept, no accept is issued for the next D crossings, where D is the short dead-time length.
- R8: After an accept, low-priority items are vetoed for the next L crossings, where L is the long window length. High-priority items are not affected by this window.
- R9: ttype, registered together with accept, is the lowest index set in rd_fin.
- R10: rd_raw, rd_pre and rd_fin are loaded only when an accept is registered and hold their values otherwise. rd_fin is a subset of rd_pre, and rd_pre is a subset of rd_raw.
- R11: A write occurs when cfg_we is 1, and cfg_kind selects what is written:
  - Kind 0 sets the selection mask of item cfg_item from cfg_data[N_IN-1:0].
  - Kind 1 sets, for item cfg_item, the enable from cfg_data[0], the high priority from cfg_data[1] and the ratio from cfg_data[2 +: PS_W].
  - Kind 2 sets the short length from cfg_data[DT_W-1:0] and the long length from cfg_data[2*DT_W-1:DT_W].
  - Kind 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | N_IN | Trigger-input bits of the current crossing |
| busy | input | 1 | Throttle from downstream; blocks accepts |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Selects the configuration field written |
| cfg_item | input | IW | Item index for kinds 0 and 1 |
| cfg_data | input | CFG_W | Configuration data |
| accept | output | 1 | Accept pulse, one per accepted crossing |
| ttype | output | TT_W | Index of the lowest surviving item |
| rd_raw | output | N_ITEM | Raw item firings at the last accept |
| rd_pre | output | N_ITEM | Items after enable and prescale at the last accept |
| rd_fin | output | N_ITEM | Items after veto at the last accept |

## Verification
A wrong prescale count shows up as an accept on the wrong firing of an item. This is visible one cycle after the crossing in which the count went wrong, or N firings later. A stuck dead-time or long-window counter either lets an accept through inside its window or blocks a low-priority item beyond the expected crossing. These faults appear at the first crossing in the affected window. Wrong readout capture shows up as rd vectors or a ttype that disagree with the accepted crossing, or as values that change without an accept.

// File: rtl/trig_menu_accept.sv
module trig_menu_accept #(
  parameter int N_IN   = 16,
  parameter int N_ITEM = 8,
  parameter int PS_W   = 8,
  parameter int DT_W   = 6,
  localparam int IW    = (N_ITEM > 1) ? $clog2(N_ITEM) : 1,
  localparam int TT_W  = IW,
  localparam int CW_A  = (N_IN > PS_W + 2) ? N_IN : PS_W + 2,
  localparam int CFG_W = (CW_A > 2 * DT_W) ? CW_A : 2 * DT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   trig_in,
  input  logic              busy,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_kind,
  input  logic [IW-1:0]     cfg_item,
  input  logic [CFG_W-1:0]  cfg_data,
  output logic              accept,
  output logic [TT_W-1:0]   ttype,
  output logic [N_ITEM-1:0] rd_raw,
  output logic [N_ITEM-1:0] rd_pre,
  output logic [N_ITEM-1:0] rd_fin
);
  logic [N_IN-1:0]   sel_q   [N_ITEM];
  logic [PS_W-1:0]   ratio_q [N_ITEM];
  logic [PS_W-1:0]   cnt_q   [N_ITEM];
  logic [N_ITEM-1:0] en_q, prio_q;
  logic [DT_W-1:0]   dts_len, dtl_len, dts_q, dtl_q;

  logic [N_ITEM-1:0] raw, hit, pre, fin;
  logic [TT_W-1:0]   tt_nxt;
  logic              acc_nxt, open_all, open_low;

  assign open_all = !busy && (dts_q == '0);
  assign open_low = (dtl_q == '0);
  assign acc_nxt  = |fin;

  always_comb begin
    for (int i = 0; i < N_ITEM; i++) begin
      logic [PS_W-1:0] r;
      r      = (ratio_q[i] == '0) ? PS_W'(1) : ratio_q[i];
      raw[i] = (sel_q[i] != '0) && ((trig_in & sel_q[i]) == sel_q[i]);
      hit[i] = raw[i] && en_q[i];
      pre[i] = hit[i] && (cnt_q[i] >= r - PS_W'(1));
      fin[i] = pre[i] && open_all && (prio_q[i] || open_low);
    end
  end

  always_comb begin
    tt_nxt = '0;
    for (int i = N_ITEM - 1; i >= 0; i--)
      if (fin[i]) tt_nxt = TT_W'(i);
  end

  wire wr_item = cfg_we && (int'(cfg_item) < N_ITEM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ITEM; i++) begin
        sel_q[i]   <= '0;
        ratio_q[i] <= '0;
        cnt_q[i]   <= '0;
      end
      en_q    <= '0;
      prio_q  <= '0;
      dts_len <= '0;
      dtl_len <= '0;
    end else begin
      for (int i = 0; i < N_ITEM; i++)
        if (hit[i]) cnt_q[i] <= pre[i] ? '0 : cnt_q[i] + PS_W'(1);
      if (wr_item && cfg_kind == 2'd0)
        sel_q[cfg_item] <= cfg_data[N_IN-1:0];
      if (wr_item && cfg_kind == 2'd1) begin
        en_q[cfg_item]    <= cfg_data[0];
        prio_q[cfg_item]  <= cfg_data[1];
        ratio_q[cfg_item] <= cfg_data[2 +: PS_W];
        cnt_q[cfg_item]   <= '0;
      end
      if (cfg_we && cfg_kind == 2'd2) begin
        dts_len <= cfg_data[DT_W-1:0];
        dtl_len <= cfg_data[DT_W +: DT_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dts_q  <= '0;
      dtl_q  <= '0;
      accept <= 1'b0;
      ttype  <= '0;
      rd_raw <= '0;
      rd_pre <= '0;
      rd_fin <= '0;
    end else begin
      accept <= acc_nxt;
      if (acc_nxt) begin
        dts_q  <= dts_len;
        dtl_q  <= dtl_len;
        ttype  <= tt_nxt;
        rd_raw <= raw;
        rd_pre <= pre;
        rd_fin <= fin;
      end else begin
        if (dts_q != '0) dts_q <= dts_q - DT_W'(1);
        if (dtl_q != '0) dtl_q <= dtl_q - DT_W'(1);
      end
    end
  end

  a_r6_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !accept);

  a_r7_short_window: assert property (@(posedge clk) disable iff (!rst_n)
    (dts_q != '0) |=> !accept);

  a_r8_low_vetoed: assert property (@(posedge clk) disable iff (!rst_n)
    (dtl_q != '0) |=> (!accept || ((rd_fin & ~$past(prio_q)) == '0)));

  a_r5_accept_has_item: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (rd_fin != '0));

  a_r10_subsets: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (((rd_fin & ~rd_pre) == '0) && ((rd_pre & ~rd_raw) == '0)));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_nxt |=> ($stable(rd_fin) && $stable(rd_raw) && $stable(ttype)));

  a_r9_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (rd_fin[ttype] &&
               ((rd_fin & ((N_ITEM'(1) << ttype) - N_ITEM'(1))) == '0)));

  a_r3_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rd_pre & ~$past(en_q)) == '0) || !accept);
endmodule

// File: tb/trig_menu_accept_tb.sv
module trig_menu_accept_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] trig_in = '0;
  logic        busy = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_kind = '0;
  logic [2:0]  cfg_item = '0;
  logic [15:0] cfg_data = '0;
  logic        accept;
  logic [2:0]  ttype;
  logic [7:0]  rd_raw, rd_pre, rd_fin;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  trig_menu_accept dut_i (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .busy(busy),
    .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_item(cfg_item), .cfg_data(cfg_data),
    .accept(accept), .ttype(ttype), .rd_raw(rd_raw), .rd_pre(rd_pre), .rd_fin(rd_fin)
  );

  // {in16, busy, acc, tt3, raw8, pre8, fin8}
  localparam int NV = 13;
  localparam logic [44:0] VEC [NV] = '{
    {16'h0000, 1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 8'h00},
    {16'h0003, 1'b0, 1'b1, 3'd0, 8'h01, 8'h01, 8'h01},
    {16'h0004, 1'b0, 1'b1, 3'd1, 8'h02, 8'h02, 8'h02},
    {16'h0018, 1'b0, 1'b0, 3'd0, 8'h04, 8'h00, 8'h00},
    {16'h0020, 1'b0, 1'b0, 3'd0, 8'h08, 8'h00, 8'h00},
    {16'h0020, 1'b0, 1'b0, 3'd0, 8'h08, 8'h00, 8'h00},
    {16'h0020, 1'b0, 1'b1, 3'd3, 8'h08, 8'h08, 8'h08},
    {16'h0007, 1'b1, 1'b0, 3'd0, 8'h03, 8'h03, 8'h00},
    {16'h0026, 1'b0, 1'b1, 3'd1, 8'h0A, 8'h02, 8'h02},
    {16'h0027, 1'b0, 1'b1, 3'd0, 8'h0B, 8'h03, 8'h03},
    {16'h003F, 1'b1, 1'b0, 3'd0, 8'h0F, 8'h0B, 8'h00},
    {16'h0020, 1'b0, 1'b0, 3'd0, 8'h08, 8'h00, 8'h00},
    {16'h0001, 1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 8'h00}
  };

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] k, input logic [2:0] it, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = k; cfg_item = it; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic step(input logic [15:0] v, input logic b);
    trig_in = v; busy = b;
    @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 accept", accept, 0);
    chk("R1 ttype", ttype, 0);
    chk("R1 rd_raw", rd_raw, 0);
    chk("R1 rd_fin", rd_fin, 0);

    // R11 programming: masks, settings
    cfg(2'd0, 3'd0, 16'h0003);
    cfg(2'd0, 3'd1, 16'h0004);
    cfg(2'd0, 3'd2, 16'h0018);
    cfg(2'd0, 3'd3, 16'h0020);
    cfg(2'd1, 3'd0, 16'h0007);
    cfg(2'd1, 3'd1, 16'h0005);
    cfg(2'd1, 3'd2, 16'h0004);
    cfg(2'd1, 3'd3, 16'h000F);
    cfg(2'd1, 3'd7, 16'h0005);   // R2 enabled item with empty mask
    cfg(2'd3, 3'd0, 16'hFFFF);   // R11 kind 3 ignored

    // Table walk: R2 R3 R4 R5 R6 R9 R10
    for (int k = 0; k < NV; k++) begin
      logic [44:0] v;
      v = VEC[k];
      step(v[44:29], v[28]);
      chk($sformatf("R5 vec%0d accept", k), accept, int'(v[27]));
      if (v[27]) begin
        chk($sformatf("R9 vec%0d ttype", k), ttype, int'(v[26:24]));
        chk($sformatf("R2 vec%0d rd_raw", k), rd_raw, int'(v[23:16]));
        chk($sformatf("R4 vec%0d rd_pre", k), rd_pre, int'(v[15:8]));
        chk($sformatf("R10 vec%0d rd_fin", k), rd_fin, int'(v[7:0]));
      end
    end
    chk("R10 hold after idle", rd_fin, 8'h03);

    // R7 / R8 dead-time: short 2, long 5
    cfg(2'd2, 3'd0, 16'h0142);
    step(16'h0003, 0); chk("R7 first accept", accept, 1);
    step(16'h0003, 0); chk("R7 short window 1", accept, 0);
    step(16'h0003, 0); chk("R7 short window 2", accept, 0);
    step(16'h0004, 0); chk("R8 low vetoed", accept, 0);
    chk("R10 hold during veto", rd_fin, 8'h01);
    step(16'h0007, 0); chk("R8 high passes", accept, 1);
    chk("R8 only high in fin", rd_fin, 8'h01);
    chk("R10 pre includes low", rd_pre, 8'h03);
    step(16'h0000, 0);
    step(16'h0000, 0);
    step(16'h0004, 0); chk("R8 low vetoed H", accept, 0);
    step(16'h0004, 0); chk("R8 low vetoed I", accept, 0);
    step(16'h0004, 0); chk("R8 low vetoed J", accept, 0);
    step(16'h0004, 0); chk("R8 low passes K", accept, 1);
    chk("R9 ttype K", ttype, 1);

    // R4 ratio 0 acts as 1
    cfg(2'd2, 3'd0, 16'h0000);
    repeat (8) step(16'h0000, 0);
    cfg(2'd1, 3'd1, 16'h0001);
    step(16'h0004, 0); chk("R4 ratio0 first", accept, 1);
    step(16'h0004, 0); chk("R4 ratio0 second", accept, 1);

    // R4 rewrite clears count: item3 ratio 2
    cfg(2'd1, 3'd3, 16'h000B);
    step(16'h0020, 0); chk("R4 ratio2 first", accept, 0);
    cfg(2'd1, 3'd3, 16'h000B);
    step(16'h0020, 0); chk("R4 cleared count", accept, 0);
    step(16'h0020, 0); chk("R4 ratio2 pass", accept, 1);
    chk("R9 ttype item3", ttype, 3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule